// File: doc/BRIEF.md
# I2C Target High-Speed Mode Tracker

This block watches a sampled I2C bus from the target side. Both lines pass through a two-flop synchronizer and a spike filter. SCL's filter width depends on the current bus speed. The filtered lines feed an event detector that finds START (including repeated START), STOP and the SCL edges. A transfer engine shifts in the first byte after every START, most significant bit first.

A first byte of the form 0000_1xxx is the master code that announces high-speed operation. The engine leaves it unacknowledged, raises `hs_mode` and holds it through any number of repeated STARTs. Only a STOP clears it. Any other first byte is reported on `addr_byte` with a one-cycle `addr_valid` strobe. The byte is acknowledged when its upper seven bits match the `TGT_ADDR` parameter. Bytes that follow a matching write address are also acknowledged.

While `hs_mode` is set, the SCL filter switches from `FS_FILT` to the shorter `HS_FILT` cycles. `slope_sel` then tells the output pad to use its high-speed edge rate.

Top module: `i2c_hs_tracker`

## Requirements
- R1: After reset `hs_mode`, `slope_sel`, `addr_valid` and `sda_oe` are all 0, and no transfer is in progress.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START during a transfer is a repeated START. The first byte after each START or repeated START is captured MSB first. If it is not a master code, it appears on `addr_byte` together with a single-cycle `addr_valid` pulse.
- R3: A first byte whose bits [7:3] equal 5'b00001 is a master code, whatever bits [2:0] hold. It sets `hs_mode` to 1 and never raises `addr_valid`.
- R4: During the ninth clock of a master code, `sda_oe` stays 0, so SDA is released.
- R5: When a first byte has bits [7:1] equal to `TGT_ADDR`, `sda_oe` is 1 from the eighth SCL falling edge until the ninth SCL falling edge. For any other first byte, `sda_oe` stays 0.
- R6: Each data byte after a matching address whose bit 0 is 0 (write) is acknowledged in the same window. Data bytes after a non-matching address are not acknowledged.
- R7: A repeated START leaves `hs_mode` at 1. The next byte is then handled as an ordinary address byte.
- R8: A STOP in any state clears `hs_mode` and the bit counter. A byte that starts after the next START is captured whole and correctly.
- R9: The filter accepts an SCL level only after it has been stable for `FS_FILT` cycles when `hs_mode` is 0, or `HS_FILT` cycles when it is 1. SCL pulses shorter than the selected width are ignored.
- R10: `slope_sel` is 1 exactly when `hs_mode` is 1, which selects the high-speed SDA edge rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| hs_mode | output | 1 | High-speed mode active |
| slope_sel | output | 1 | SDA pad edge-rate select, 1 for high speed |
| addr_valid | output | 1 | One-cycle strobe for a new address byte |
| addr_byte | output | 8 | Last address byte received |
| sda_oe | output | 1 | Pull SDA low (acknowledge drive) |

## Verification
The assertions assume that, once filtered, SDA changes only while SCL is low, except at START and STOP. They also assume the bus never produces a pulse that the filter accepts as a real edge in the middle of a bit. The stimulus moves SDA halfway through each SCL low phase. Its half-periods are about twice the synchronizer-plus-filter delay: 20 cycles at normal speed and 7 cycles at high speed. Every glitch it injects is shorter than the filter width in force at that moment. The 7-cycle high-speed half-period is below `FS_FILT`, so high-speed transfers only decode if the narrower filter has really been selected.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = 4;

    // bits [7:3] of a master code byte
    localparam logic [4:0] HS_CODE_TOP = 5'b00001;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_t;

    typedef struct packed {
        phase_t              phase;
        logic [BIT_CW-1:0]   bitc;
        logic [BYTE_W-1:0]   sr;
        logic [BYTE_W-1:0]   abyte;
        logic                av;
        logic                hs;
        logic                oe;
        logic                ack_pend;
        logic                wsel;
    } xfer_st_t;

endpackage

// File: rtl/hst_spike_filter.sv
module hst_spike_filter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_i,
    input  logic [CW-1:0] lim_i,
    output logic          out_o
);

    typedef struct packed {
        logic [1:0]    sync;
        logic          out;
        logic [CW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], raw_i};
        if (st_q.sync[1] == st_q.out) begin
            st_d.cnt = '0;
        end else if ((st_q.cnt + CW'(1)) >= lim_i) begin
            st_d.out = st_q.sync[1];
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= 2'b11;
            st_q.out  <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    // R9
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.out) |-> ($past(st_q.sync[1]) == st_q.out));

    // R9
    filt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sync[1] == st_q.out) |=> (st_q.cnt == '0));

endmodule

// File: rtl/hst_bus_events.sv
module hst_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_st_t;

    line_st_t prev_q, prev_d;

    always_comb begin
        prev_d.scl = scl_f;
        prev_d.sda = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

    assign start_o = scl_f &&  prev_q.scl &&  prev_q.sda && !sda_f;
    assign stop_o  = scl_f &&  prev_q.scl && !prev_q.sda &&  sda_f;
    assign rise_o  = scl_f && !prev_q.scl;
    assign fall_o  = !scl_f && prev_q.scl;

    // R2
    ev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o, rise_o, fall_o}));

endmodule

// File: rtl/hst_xfer_fsm.sv
module hst_xfer_fsm
    import i2c_hs_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              sda_i,
    output logic              hs_o,
    output logic              av_o,
    output logic [BYTE_W-1:0] abyte_o,
    output logic              oe_o
);

    xfer_st_t q, d;
    logic [BYTE_W-1:0] nb;
    logic              is_code;
    logic              is_mine;

    assign nb      = {q.sr[BYTE_W-2:0], sda_i};
    assign is_code = (nb[7:3] == HS_CODE_TOP);
    assign is_mine = (nb[7:1] == TGT_ADDR);

    always_comb begin
        d    = q;
        d.av = 1'b0;
        if (stop_i) begin
            d.phase    = PH_IDLE;
            d.bitc     = '0;
            d.oe       = 1'b0;
            d.hs       = 1'b0;
            d.ack_pend = 1'b0;
            d.wsel     = 1'b0;
        end else if (start_i) begin
            d.phase    = PH_ADDR;
            d.bitc     = '0;
            d.oe       = 1'b0;
            d.ack_pend = 1'b0;
            d.wsel     = 1'b0;
        end else if (rise_i && q.phase != PH_IDLE) begin
            if (q.bitc < BIT_CW'(8)) begin
                d.sr   = nb;
                d.bitc = q.bitc + BIT_CW'(1);
                if (q.bitc == BIT_CW'(7)) begin
                    case (q.phase)
                        PH_ADDR: begin
                            if (is_code) begin
                                d.hs       = 1'b1;
                                d.phase    = PH_SKIP;
                                d.ack_pend = 1'b0;
                            end else begin
                                d.av       = 1'b1;
                                d.abyte    = nb;
                                d.ack_pend = is_mine;
                                d.wsel     = is_mine && !nb[0];
                                d.phase    = PH_DATA;
                            end
                        end
                        PH_DATA: d.ack_pend = q.wsel;
                        default: d.ack_pend = 1'b0;
                    endcase
                end
            end else if (q.bitc == BIT_CW'(8)) begin
                d.bitc = BIT_CW'(9);
            end
        end else if (fall_i && q.phase != PH_IDLE) begin
            if (q.bitc == BIT_CW'(8)) begin
                d.oe = q.ack_pend;
            end else if (q.bitc == BIT_CW'(9)) begin
                d.oe       = 1'b0;
                d.bitc     = '0;
                d.ack_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase    <= PH_IDLE;
            q.bitc     <= '0;
            q.sr       <= '0;
            q.abyte    <= '0;
            q.av       <= 1'b0;
            q.hs       <= 1'b0;
            q.oe       <= 1'b0;
            q.ack_pend <= 1'b0;
            q.wsel     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign hs_o    = q.hs;
    assign av_o    = q.av;
    assign abyte_o = q.abyte;
    assign oe_o    = q.oe;

    // R3
    hs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.hs) |-> $past(rise_i && q.phase == PH_ADDR && q.bitc == BIT_CW'(7)));

    // R3
    av_not_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.av |-> (q.abyte[7:3] != HS_CODE_TOP));

    // R4
    skip_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_SKIP) |-> !q.oe);

    // R5
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> (q.bitc == BIT_CW'(8) || q.bitc == BIT_CW'(9)));

    // R7
    hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_i) && $past(q.hs)) |-> q.hs);

    // R8
    hs_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.hs) |-> $past(stop_i));

    // R8
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (q.bitc == '0 && !q.hs && !q.oe));

endmodule

// File: rtl/i2c_hs_tracker.sv
module i2c_hs_tracker
    import i2c_hs_pkg::*;
#(
    parameter int         FS_FILT  = 10,
    parameter int         HS_FILT  = 2,
    parameter int         SDA_FILT = 2,
    parameter logic [6:0] TGT_ADDR = 7'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              hs_mode,
    output logic              slope_sel,
    output logic              addr_valid,
    output logic [BYTE_W-1:0] addr_byte,
    output logic              sda_oe
);

    localparam int FMAX_A = (FS_FILT > HS_FILT) ? FS_FILT : HS_FILT;
    localparam int FMAX   = (FMAX_A > SDA_FILT) ? FMAX_A : SDA_FILT;
    localparam int CW     = $clog2(FMAX + 1);

    logic          hs_w;
    logic [CW-1:0] scl_lim;
    logic          scl_f, sda_f;
    logic          ev_start, ev_stop, ev_rise, ev_fall;

    assign scl_lim = hs_w ? CW'(HS_FILT) : CW'(FS_FILT);

    hst_spike_filter #(.CW(CW)) u_scl_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (scl_i),
        .lim_i (scl_lim),
        .out_o (scl_f)
    );

    hst_spike_filter #(.CW(CW)) u_sda_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (sda_i),
        .lim_i (CW'(SDA_FILT)),
        .out_o (sda_f)
    );

    hst_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .start_o (ev_start),
        .stop_o  (ev_stop),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall)
    );

    hst_xfer_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ev_start),
        .stop_i  (ev_stop),
        .rise_i  (ev_rise),
        .fall_i  (ev_fall),
        .sda_i   (sda_f),
        .hs_o    (hs_w),
        .av_o    (addr_valid),
        .abyte_o (addr_byte),
        .oe_o    (sda_oe)
    );

    assign hs_mode   = hs_w;
    assign slope_sel = hs_w;

    initial begin
        // R9
        filt_param_chk: assert (HS_FILT > 0 && FS_FILT > 0 && SDA_FILT > 0);
    end

    // R10
    slope_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slope_sel == hs_mode);

    // R2
    av_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> !addr_valid);

endmodule

// File: tb/i2c_hs_tracker_test.sv
module i2c_hs_tracker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       hs_mode, slope_sel, addr_valid, sda_oe;
    logic [7:0] addr_byte;
    logic       sda_bus;

    int n_chk = 0;
    int n_bad = 0;
    int av_cnt = 0;
    logic [7:0] av_last = 8'h00;
    int hp = 20;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_hs_tracker uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .hs_mode    (hs_mode),
        .slope_sel  (slope_sel),
        .addr_valid (addr_valid),
        .addr_byte  (addr_byte),
        .sda_oe     (sda_oe)
    );

    always @(negedge clk) begin
        if (rst_n && addr_valid) begin
            av_cnt  = av_cnt + 1;
            av_last = addr_byte;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wt(hp);
        sda_m = 1'b0; wt(hp);
        scl_m = 1'b0; wt(hp / 2);
    endtask

    task automatic bus_rstart();
        wt(hp / 2); sda_m = 1'b1; wt(hp - hp / 2);
        scl_m = 1'b1; wt(hp);
        sda_m = 1'b0; wt(hp);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wt(hp / 2); sda_m = 1'b0; wt(hp - hp / 2);
        scl_m = 1'b1; wt(hp);
        sda_m = 1'b1; wt(3 * hp);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits, input int gbit, input int glen);
        for (int i = 7; i > 7 - nbits; i--) begin
            wt(hp / 2); sda_m = b[i]; wt(hp - hp / 2);
            scl_m = 1'b1;
            if (glen > 0 && i == gbit) begin
                wt(hp / 2); scl_m = 1'b0; wt(glen); scl_m = 1'b1;
                wt(hp - hp / 2 - glen);
            end else begin
                wt(hp);
            end
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int gbit, input int glen, output logic ack);
        send_bits(b, 8, gbit, glen);
        wt(hp / 2); sda_m = 1'b1; wt(hp - hp / 2);
        scl_m = 1'b1; wt(hp - 1);
        ack = sda_oe;
        wt(1);
        scl_m = 1'b0;
    endtask

    task automatic t_reset();
        chk(hs_mode == 1'b0, "R1 hs_mode", hs_mode, 0);
        chk(slope_sel == 1'b0, "R1 slope_sel", slope_sel, 0);
        chk(addr_valid == 1'b0, "R1 addr_valid", addr_valid, 0);
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    endtask

    task automatic t_fs_write();
        logic ack; int c0;
        hp = 20; c0 = av_cnt;
        bus_start();
        send_byte(8'hC2, -1, 0, ack);
        chk(av_cnt == c0 + 1, "R2 addr strobe count", av_cnt - c0, 1);
        chk(av_last == 8'hC2, "R2 addr byte", av_last, 8'hC2);
        chk(ack == 1'b1, "R5 own addr ack", ack, 1);
        send_byte(8'h5A, -1, 0, ack);
        chk(ack == 1'b1, "R6 write data ack", ack, 1);
        chk(av_cnt == c0 + 1, "R2 data no strobe", av_cnt - c0, 1);
        bus_stop();
    endtask

    task automatic t_fs_other();
        logic ack;
        hp = 20;
        bus_start();
        send_byte(8'h90, -1, 0, ack);
        chk(av_last == 8'h90, "R2 other addr byte", av_last, 8'h90);
        chk(ack == 1'b0, "R5 other addr no ack", ack, 0);
        send_byte(8'h11, -1, 0, ack);
        chk(ack == 1'b0, "R6 data after other addr no ack", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hC3, -1, 0, ack);
        chk(av_last == 8'hC3, "R2 read addr byte", av_last, 8'hC3);
        chk(ack == 1'b1, "R5 own read addr ack", ack, 1);
        bus_stop();
    endtask

    task automatic t_hs_session(input logic [7:0] code);
        logic ack; int c0;
        hp = 20; c0 = av_cnt;
        bus_start();
        send_byte(code, -1, 0, ack);
        chk(ack == 1'b0, "R4 master code no ack", ack, 0);
        chk(av_cnt == c0, "R3 master code no strobe", av_cnt - c0, 0);
        chk(hs_mode == 1'b1, "R3 hs_mode set", hs_mode, 1);
        chk(slope_sel == 1'b1, "R10 slope_sel high speed", slope_sel, 1);
        hp = 7;
        bus_rstart();
        send_byte(8'hC2, -1, 0, ack);
        chk(av_last == 8'hC2, "R9 narrow filter decodes fast clock", av_last, 8'hC2);
        chk(ack == 1'b1, "R7 addr ack after repeated start", ack, 1);
        send_byte(8'hA5, -1, 0, ack);
        chk(ack == 1'b1, "R6 high speed data ack", ack, 1);
        chk(hs_mode == 1'b1, "R7 hs_mode kept", hs_mode, 1);
        bus_rstart();
        send_byte(8'h90, -1, 0, ack);
        chk(ack == 1'b0, "R7 other addr at high speed", ack, 0);
        chk(av_last == 8'h90, "R7 second addr byte", av_last, 8'h90);
        bus_rstart();
        send_byte(8'hC4, 4, 1, ack);
        chk(av_last == 8'hC4, "R9 short glitch ignored at high speed", av_last, 8'hC4);
        chk(hs_mode == 1'b1, "R7 hs_mode after second repeated start", hs_mode, 1);
        bus_stop();
        chk(hs_mode == 1'b0, "R8 stop leaves high speed", hs_mode, 0);
        chk(slope_sel == 1'b0, "R10 slope_sel back", slope_sel, 0);
    endtask

    task automatic t_fs_glitch();
        logic ack;
        hp = 20;
        bus_start();
        send_byte(8'hC2, 2, 6, ack);
        chk(av_last == 8'hC2, "R9 glitch ignored at normal speed", av_last, 8'hC2);
        chk(ack == 1'b1, "R9 ack after glitch", ack, 1);
        bus_stop();
    endtask

    task automatic t_stop_midbyte();
        logic ack;
        hp = 20;
        bus_start();
        send_byte(8'h08, -1, 0, ack);
        chk(hs_mode == 1'b1, "R3 code 0x08 sets hs", hs_mode, 1);
        hp = 7;
        bus_rstart();
        send_bits(8'hFF, 3, -1, 0);
        bus_stop();
        chk(hs_mode == 1'b0, "R8 stop mid byte clears hs", hs_mode, 0);
        hp = 20;
        bus_start();
        send_byte(8'h3C, -1, 0, ack);
        chk(av_last == 8'h3C, "R8 byte after mid-byte stop", av_last, 8'h3C);
        bus_stop();
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_fs_write();
        t_fs_other();
        t_hs_session(8'h0B);
        t_hs_session(8'h0F);
        t_fs_glitch();
        t_stop_midbyte();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule